// File: doc/BRIEF.md
# Burst-of-Two Separate-I/O Synchronous SRAM Model

This block is a synthesizable cycle model of a synchronous SRAM. It has separate input and output data buses, and every access moves a burst of two data beats. Each data-rate edge of the modelled device appears as one cycle of a single fast clock. An internal phase bit alternates between a first-beat cycle and a second-beat cycle, and each pair of cycles forms one bus cycle. The phase is brought out on `beat2` so that the surrounding logic can align its commands.

The storage array is twice as wide as the data bus, so one address selects one wide word. A write command is taken on a first-beat cycle. The first data beat and its per-lane write enables are sampled in that cycle. The second beat and its enables are sampled in the following cycle, and the merged wide word is then written to the array in one operation. A read command is also taken on a first-beat cycle. Its wide word is split into a low beat and a high beat, which appear on the read bus two bus cycles later, with `rvalid` flagging both beats.

A read and a write may be issued in the same bus cycle. A read issued in the same bus cycle as a write to the same address returns the freshly written lanes.

Top module: `b2_qsram`

## Requirements
- R1: After reset, `beat2` is 0 in the first cycle and then toggles every cycle. A cycle with `beat2`=0 is a first-beat cycle.
- R2: A read command sampled at the clock edge closing a first-beat cycle (edge k) puts word bits [DW-1:0] on `rdata` after edge k+4 and bits [2*DW-1:DW] after edge k+5.
- R3: A write gathers two beats into one array word addressed by a wide-word address. The beat sampled with the command forms bits [DW-1:0] and the next beat forms bits [2*DW-1:DW].
- R4: The write enables are active low and are sampled separately with each beat. Bit i of `wbe_n` guards lane i, which is bits [9i+8:9i] of that beat. A lane whose bit is 1 keeps its old content.
- R5: A read and a write to different addresses issued in the same bus cycle are both carried out.
- R6: A read sees every write whose command was sampled in the same bus cycle or earlier, merged lane by lane. It does not see a write issued in a later bus cycle.
- R7: `rvalid` is 1 on exactly the two cycles carrying the beats of a read and is 0 otherwise.
- R8: While `rvalid` is 0, `rdata` holds its previous value.
- R9: Read and write commands presented in a second-beat cycle are ignored. They produce no read output and change no stored data.
- R10: During reset, `rvalid` is 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one cycle per data beat |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_n | input | 1 | Active-low read command, taken in first-beat cycles |
| wr_n | input | 1 | Active-low write command, taken in first-beat cycles |
| rd_addr | input | AW | Wide-word read address |
| wr_addr | input | AW | Wide-word write address |
| wdata | input | DW | Write data beat |
| wbe_n | input | LANES | Per-beat active-low lane write enables |
| rdata | output | DW | Read data beat |
| rvalid | output | 1 | Read beat valid flag |
| beat2 | output | 1 | 1 in second-beat cycles |

## Verification
A phase bit that slips makes the read beats land a cycle late or swaps their halves. The first read after the slip then shows the wrong data, exactly four or five edges after its command. A stale gather register or a broken merge of the write enables shows up only when the affected address is read back. That readback comes at least two bus cycles after the write. A missing forward of an in-flight write shows up at once, in the read issued in the same bus cycle as the write. A stuck pipeline stage gives a valid flag that is missing, lasts one beat, or lasts more than two beats, within three bus cycles of the read.

// File: rtl/b2_sram_pkg.sv
package b2_sram_pkg;
  typedef enum logic {BEAT_FIRST = 1'b0, BEAT_SECOND = 1'b1} beat_e;

  // width of one write-enable lane
  function automatic int lane_width(int dw, int lanes);
    return dw / lanes;
  endfunction
endpackage

// File: rtl/b2_beat_ctl.sv
module b2_beat_ctl
  import b2_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] rd_addr,
  output beat_e         phase,
  output logic          rd_accept,
  output logic          wr_accept,
  output logic          rd_req_q,
  output logic [AW-1:0] rd_addr_q
);
  function automatic beat_e next_beat(beat_e b);
    return (b == BEAT_FIRST) ? BEAT_SECOND : BEAT_FIRST;
  endfunction

  assign rd_accept = (phase == BEAT_FIRST) && !rd_n;
  assign wr_accept = (phase == BEAT_FIRST) && !wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= BEAT_FIRST;
      rd_req_q  <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      phase    <= next_beat(phase);
      rd_req_q <= rd_accept;
      if (rd_accept) rd_addr_q <= rd_addr;
    end
  end

  AST_PHASE_FIRST_TO_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == BEAT_FIRST) |=> (phase == BEAT_SECOND)); // R1
  AST_PHASE_SECOND_TO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == BEAT_SECOND) |=> (phase == BEAT_FIRST)); // R1
endmodule

// File: rtl/b2_write_gather.sv
module b2_write_gather
  import b2_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 36,
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  beat_e             phase,
  input  logic              wr_accept,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wdata,
  input  logic [LANES-1:0]  wbe_n,
  output logic              arr_we,
  output logic [AW-1:0]     arr_waddr,
  output logic [2*DW-1:0]   arr_wdata,
  output logic [2*LANES-1:0] arr_wen_n
);
  localparam int WW = 2 * DW;
  localparam int NL = 2 * LANES;

  logic [DW-1:0]    lo_q;
  logic [LANES-1:0] mlo_q;
  logic [AW-1:0]    addr_q;
  logic             pend_q;

  function automatic logic [WW-1:0] join_beats(logic [DW-1:0] lo, logic [DW-1:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic [NL-1:0] join_masks(logic [LANES-1:0] lo, logic [LANES-1:0] hi);
    return {hi, lo};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lo_q   <= '0;
      mlo_q  <= '1;
      addr_q <= '0;
    end else begin
      pend_q <= wr_accept;
      if (wr_accept) begin
        lo_q   <= wdata;
        mlo_q  <= wbe_n;
        addr_q <= wr_addr;
      end
    end
  end

  assign arr_we    = pend_q && (phase == BEAT_SECOND);
  assign arr_waddr = addr_q;
  assign arr_wdata = join_beats(lo_q, wdata);
  assign arr_wen_n = join_masks(mlo_q, wbe_n);

  AST_GATHER_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (phase == BEAT_SECOND)); // R3
  AST_GATHER_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (lo_q == $past(wdata))); // R3
endmodule

// File: rtl/b2_array.sv
module b2_array
  import b2_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 36,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [2*DW-1:0]    wdata,
  input  logic [2*LANES-1:0] wen_n,
  input  logic [AW-1:0]      raddr,
  output logic [2*DW-1:0]    rword,
  output logic               fwd_hit
);
  localparam int WW    = 2 * DW;
  localparam int NL    = 2 * LANES;
  localparam int LW    = lane_width(DW, LANES);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  // lane-by-lane merge of new data over old data; enable active low
  function automatic logic [WW-1:0] merge_lanes(logic [WW-1:0] old_w,
                                                logic [WW-1:0] new_w,
                                                logic [NL-1:0] en_n);
    logic [WW-1:0] r;
    r = old_w;
    for (int l = 0; l < NL; l++) begin
      if (!en_n[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= merge_lanes(mem[waddr], wdata, wen_n);
  end

  assign fwd_hit = we && (waddr == raddr);
  assign rword   = fwd_hit ? merge_lanes(mem[raddr], wdata, wen_n) : mem[raddr];

  AST_FORWARD_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |=> (mem[$past(raddr)] == $past(rword))); // R6
endmodule

// File: rtl/b2_read_seq.sv
module b2_read_seq
  import b2_sram_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic            clk,
  input  logic            rst_n,
  input  beat_e           phase,
  input  logic            rd_req_q,
  input  logic [2*DW-1:0] rword,
  output logic [DW-1:0]   rdata,
  output logic            rvalid,
  output logic            cap_evt
);
  localparam int WW = 2 * DW;

  logic [WW-1:0] s1_q, s2_q;
  logic          s1v_q, s2v_q;
  logic          adv;

  function automatic logic [DW-1:0] beat_slice(logic [WW-1:0] w, beat_e b);
    return (b == BEAT_FIRST) ? w[DW-1:0] : w[WW-1:DW];
  endfunction

  assign adv     = (phase == BEAT_SECOND);
  assign cap_evt = adv && rd_req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s1v_q  <= 1'b0;
      s2v_q  <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      if (adv) begin
        if (rd_req_q) s1_q <= rword;
        s1v_q <= rd_req_q;
        s2_q  <= s1_q;
        s2v_q <= s1v_q;
      end
      rvalid <= s2v_q;
      if (s2v_q) rdata <= beat_slice(s2_q, phase);
    end
  end

  AST_VALID_TWO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |=> rvalid); // R7
  AST_VALID_STARTS_LOW_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> (phase == BEAT_SECOND)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> $stable(rdata)); // R8
endmodule

// File: rtl/b2_qsram.sv
module b2_qsram
  import b2_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 36,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [AW-1:0]    rd_addr,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wbe_n,
  output logic [DW-1:0]    rdata,
  output logic             rvalid,
  output logic             beat2
);
  localparam int WW = 2 * DW;
  localparam int NL = 2 * LANES;

  beat_e         phase;
  logic          rd_accept, wr_accept, rd_req_q;
  logic [AW-1:0] rd_addr_q;
  logic          arr_we;
  logic [AW-1:0] arr_waddr;
  logic [WW-1:0] arr_wdata;
  logic [NL-1:0] arr_wen_n;
  logic [WW-1:0] rword;
  logic          fwd_hit;
  logic          cap_evt;

  b2_beat_ctl #(.AW(AW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .rd_addr(rd_addr),
    .phase(phase), .rd_accept(rd_accept), .wr_accept(wr_accept),
    .rd_req_q(rd_req_q), .rd_addr_q(rd_addr_q)
  );

  b2_write_gather #(.AW(AW), .DW(DW), .LANES(LANES)) u_wg (
    .clk(clk), .rst_n(rst_n), .phase(phase), .wr_accept(wr_accept),
    .wr_addr(wr_addr), .wdata(wdata), .wbe_n(wbe_n),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .arr_wen_n(arr_wen_n)
  );

  b2_array #(.AW(AW), .DW(DW), .LANES(LANES)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .wen_n(arr_wen_n), .raddr(rd_addr_q), .rword(rword), .fwd_hit(fwd_hit)
  );

  b2_read_seq #(.DW(DW)) u_rs (
    .clk(clk), .rst_n(rst_n), .phase(phase), .rd_req_q(rd_req_q), .rword(rword),
    .rdata(rdata), .rvalid(rvalid), .cap_evt(cap_evt)
  );

  assign beat2 = (phase == BEAT_SECOND);

  AST_READ_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> cap_evt); // R2
  AST_REQ_ONLY_FROM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_q |-> (phase == BEAT_SECOND)); // R9
  AST_FWD_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_hit && rd_req_q) |=> cap_evt == 1'b0); // R6
endmodule

// File: tb/tb_b2_qsram.sv
module tb_b2_qsram;
  localparam int AW = 6, DW = 36, LANES = 4, LW = 9, WW = 72, DEPTH = 64, RING = 256;

  logic             clk = 1'b0, rst_n = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0]    rd_addr = '0, wr_addr = '0;
  logic [DW-1:0]    wdata = '0;
  logic [LANES-1:0] wbe_n = '1;
  wire  [DW-1:0]    rdata;
  wire              rvalid, beat2;

  b2_qsram #(.AW(AW), .DW(DW), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .rd_addr(rd_addr),
    .wr_addr(wr_addr), .wdata(wdata), .wbe_n(wbe_n), .rdata(rdata),
    .rvalid(rvalid), .beat2(beat2)
  );

  always #4 clk = ~clk;

  int edges = 0;
  always @(posedge clk) edges <= edges + 1;

  int n_chk = 0, n_bad = 0;
  bit mon_on = 1'b0, done = 1'b0;
  logic [WW-1:0] ref_mem [DEPTH];
  logic          exp_v [RING];
  logic [DW-1:0] exp_d [RING];
  string         exp_tag [RING];
  logic [DW-1:0] last_d = '0;

  task automatic check(bit ok, string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at edge %0d", tag, act, exp, edges);
    end
  endtask

  // output monitor: expected beats are scheduled by edge count
  always @(negedge clk) begin : mon
    int i;
    if (mon_on) begin
      i = edges % RING;
      if (exp_v[i]) begin
        check(rvalid == 1'b1, {exp_tag[i], " valid"}, WW'(rvalid), WW'(1));
        check(rdata == exp_d[i], exp_tag[i], WW'(rdata), WW'(exp_d[i]));
        last_d   = exp_d[i];
        exp_v[i] = 1'b0;
      end else begin
        check(rvalid == 1'b0, "R7 idle valid", WW'(rvalid), WW'(0));
        check(rdata == last_d, "R8 idle hold", WW'(rdata), WW'(last_d));
      end
    end
  end

  function automatic logic [WW-1:0] pat(int a, int salt);
    logic [DW-1:0] hi, lo;
    hi = DW'(a * 36'h1234567 + salt * 36'h0f0f);
    lo = DW'(~(a * 36'h0abcdef) ^ (salt * 36'h5a5));
    return {hi, lo};
  endfunction

  task automatic ref_write(logic [AW-1:0] a, logic [DW-1:0] d0, logic [LANES-1:0] m0,
                           logic [DW-1:0] d1, logic [LANES-1:0] m1);
    for (int b = 0; b < DW; b++) begin
      if (!m0[b / LW]) ref_mem[a][b] = d0[b];
      if (!m1[b / LW]) ref_mem[a][DW + b] = d1[b];
    end
  endtask

  // one bus cycle; called at a negedge before a first-beat cycle
  task automatic bus(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                     logic [DW-1:0] d0, logic [LANES-1:0] m0,
                     logic [DW-1:0] d1, logic [LANES-1:0] m1, string tag);
    int k;
    if (wr) ref_write(wa, d0, m0, d1, m1);
    if (rd) begin
      k = edges + 1;
      exp_v[(k + 4) % RING] = 1'b1; exp_d[(k + 4) % RING] = ref_mem[ra][DW-1:0];
      exp_tag[(k + 4) % RING] = {tag, " low beat"};
      exp_v[(k + 5) % RING] = 1'b1; exp_d[(k + 5) % RING] = ref_mem[ra][WW-1:DW];
      exp_tag[(k + 5) % RING] = {tag, " high beat"};
    end
    rd_n = !rd; wr_n = !wr; rd_addr = ra; wr_addr = wa; wdata = d0; wbe_n = m0;
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; wdata = d1; wbe_n = m1;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) bus(0, '0, 0, '0, '0, '1, '0, '1, "");
  endtask

  task automatic t_reset();
    check(rvalid == 1'b0, "R10 rvalid in reset", WW'(rvalid), WW'(0));
    check(rdata == '0, "R10 rdata in reset", WW'(rdata), WW'(0));
    rst_n = 1'b1;
    check(beat2 == 1'b0, "R1 first cycle", WW'(beat2), WW'(0));
    @(negedge clk);
    check(beat2 == 1'b1, "R1 second cycle", WW'(beat2), WW'(1));
    @(negedge clk);
    check(beat2 == 1'b0, "R1 third cycle", WW'(beat2), WW'(0));
    mon_on = 1'b1;
  endtask

  task automatic t_fill();   // R3: every wide word written from two beats
    for (int a = 0; a < DEPTH; a++) begin
      logic [WW-1:0] w;
      w = pat(a, 1);
      bus(0, '0, 1, AW'(a), w[DW-1:0], '0, w[WW-1:DW], '0, "R3");
    end
  endtask

  task automatic t_readback();  // R2: back-to-back reads, latency and beat order
    for (int a = 0; a < DEPTH; a++) bus(1, AW'(a), 0, '0, '0, '1, '0, '1, "R2 R3 readback");
    idle(1);
    for (int a = DEPTH - 1; a >= 0; a -= 7) begin
      bus(1, AW'(a), 0, '0, '0, '1, '0, '1, "R2 spaced");
      idle(1);
    end
    idle(3);
  endtask

  task automatic t_simul();  // R5: read and write different addresses together
    for (int a = 0; a < 16; a++) begin
      logic [WW-1:0] w;
      w = pat(a, 7);
      bus(1, AW'(a + 20), 1, AW'(a), w[DW-1:0], '0, w[WW-1:DW], '0, "R5 concurrent");
    end
    for (int a = 0; a < 16; a++) bus(1, AW'(a), 0, '0, '0, '1, '0, '1, "R5 written");
    idle(3);
  endtask

  task automatic t_masked();  // R4: per-beat active-low lane enables
    bus(0, '0, 1, 6'd40, 36'hAAAAAAAAA, 4'b1010, 36'h555555555, 4'b0101, "R4");
    bus(0, '0, 1, 6'd41, 36'h123456789, 4'b1111, 36'h987654321, 4'b0111, "R4");
    bus(0, '0, 1, 6'd42, 36'hFFFFFFFFF, 4'b1111, 36'hFFFFFFFFF, 4'b1111, "R4");
    bus(1, 6'd40, 0, '0, '0, '1, '0, '1, "R4 split masks");
    bus(1, 6'd41, 0, '0, '0, '1, '0, '1, "R4 one lane");
    bus(1, 6'd42, 0, '0, '0, '1, '0, '1, "R4 all masked");
    idle(3);
  endtask

  task automatic t_coherent();  // R6: same-cycle forward and ordering
    bus(1, 6'd50, 1, 6'd50, 36'h0DEADBEEF, 4'b0110, 36'h0CAFEF00D, 4'b1001, "R6 same cycle");
    bus(1, 6'd51, 0, '0, '0, '1, '0, '1, "R6 before later write");
    bus(0, '0, 1, 6'd51, 36'h111111111, 4'b0000, 36'h222222222, 4'b0000, "R6");
    bus(1, 6'd51, 0, '0, '0, '1, '0, '1, "R6 after write");
    bus(1, 6'd52, 1, 6'd52, 36'h333333333, 4'b0000, 36'h444444444, 4'b0000, "R6 full");
    bus(1, 6'd52, 1, 6'd52, 36'h666666666, 4'b1100, 36'h777777777, 4'b0011, "R6 back to back");
    idle(3);
  endtask

  task automatic t_ignore();  // R9: commands in second-beat cycles do nothing
    @(negedge clk);
    rd_n = 1'b0; wr_n = 1'b0; rd_addr = 6'd45; wr_addr = 6'd45;
    wdata = 36'hBADBADBAD; wbe_n = '0;
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; wbe_n = '1;
    idle(3);
    bus(1, 6'd45, 0, '0, '0, '1, '0, '1, "R9 unchanged");
    idle(3);
  endtask

  initial begin
    for (int i = 0; i < RING; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; exp_tag[i] = ""; end
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_readback();
    t_simul();
    t_masked();
    t_coherent();
    t_ignore();
    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule